// File: doc/BRIEF.md
# Bitfield Insert Unit

This block merges a contiguous run of bits from a source word into a destination word. The location and length of the run are not carried by the operation itself: they are packed into a side control word that the caller presents alongside the two operands. The run is taken from the source at the same bit positions it lands on in the result. The source is masked in place, never shifted. Every destination bit outside the run is passed through untouched. A run that is empty or that would reach past the top of the word is rejected, and the destination word is returned as it was.

A second mode, chosen by a one-bit operation input, reverses the bit order of the lower half of the destination operand and zeroes the upper half. Operands are accepted whenever the input valid strobe is high. The result appears, together with an output valid strobe, one clock edge later. There is no back-pressure.

Top module: `bitfield_insert_unit`

## Requirements
- R1: The run's lowest bit index is read from `in_ctrl[4:0]` and its length from `in_ctrl[11:7]`. Control bits 5, 6 and 12 to 31 have no effect on the result.
- R2: With `in_op` = 0 and a legal run, the result is `(in_rs & M) | (in_rt & ~M)`. Here M has ones at indices pos through pos+len−1 and zeros elsewhere, and `in_rs` is not shifted.
- R3: With `in_op` = 0 and a length of zero, the result equals `in_rt` for every position, position 0 included.
- R4: With `in_op` = 0 and pos + len greater than 32, so that the run's top bit would be 32 or above, the result equals `in_rt`.
- R5: With `in_op` = 1, result bit 15−i equals `in_rt[i]` for i in 0..15, and result bits 31:16 are zero. `in_rs` and `in_ctrl` have no effect.
- R6: `out_valid` is high in the cycle after an edge that sampled `in_valid` high, and low after an edge that sampled it low. `out_data` keeps its value across edges where `in_valid` is low.
- R7: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and control are sampled on this edge |
| in_op | input | 1 | 0 = insert run, 1 = reverse low half |
| in_rs | input | 32 | Source word supplying the run bits |
| in_rt | input | 32 | Destination word |
| in_ctrl | input | 32 | Control word holding run position and length |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 32 | Registered result |

## Verification
The bench sweeps all 1024 position and length pairs against a per-bit reference. That sweep catches a comparison that lets a zero length at position 0 through, which would corrupt bit 0 or the whole word. It also catches an off-by-one at the word-top boundary, which would accept pos+len = 33 or reject pos+len = 32. Noise in the unused control bits exposes a decoder that takes a field at the wrong offset or width. Reversal patterns with an asymmetric low half, and junk in the upper half, expose a mirror that is reversed over the wrong span or that leaks upper bits. Idle cycles with changing operands expose a register that loads without the valid strobe.

// File: rtl/bitins_pkg.sv
package bitins_pkg;

   // Operation select carried on in_op
   typedef enum logic {
      OP_INSERT = 1'b0,
      OP_BITREV = 1'b1
   } bitins_op_e;

   // Mask construction variants
   localparam int MASK_SHIFT  = 0;
   localparam int MASK_THERMO = 1;

endpackage

// File: rtl/bitins_field_decode.sv
module bitins_field_decode #(
   parameter int DATA_W   = 32,
   parameter int CTRL_W   = 32,
   parameter int POS_LSB  = 0,
   parameter int POS_W    = 5,
   parameter int SIZE_LSB = 7,
   parameter int SIZE_W   = 5,
   parameter int SUM_W    = ((POS_W > SIZE_W) ? POS_W : SIZE_W) + 1
) (
   input  logic [CTRL_W-1:0] ctrl,
   output logic [POS_W-1:0]  fld_pos,
   output logic [SIZE_W-1:0] fld_len,
   output logic [SUM_W-1:0]  fld_end,
   output logic              fld_ok
);

   localparam logic [SUM_W-1:0] WORD_TOP = SUM_W'(DATA_W);

   if (POS_LSB + POS_W > CTRL_W) begin : g_bad_pos
      $error("position field lies outside the control word");
   end
   if (SIZE_LSB + SIZE_W > CTRL_W) begin : g_bad_size
      $error("length field lies outside the control word");
   end
   if ((2 ** POS_W) < DATA_W) begin : g_bad_posw
      $error("position field too narrow for the data width");
   end
   if ((2 ** SUM_W) <= DATA_W) begin : g_bad_sumw
      $error("sum width cannot hold the data width");
   end

   always_comb begin
      fld_pos = ctrl[POS_LSB +: POS_W];
      fld_len = ctrl[SIZE_LSB +: SIZE_W];
      // one past the top bit of the run
      fld_end = SUM_W'(fld_pos) + SUM_W'(fld_len);
      // empty runs and runs crossing the word top are refused
      fld_ok  = (fld_len != '0) && (fld_end <= WORD_TOP);
   end

endmodule

// File: rtl/bitins_mask_gen.sv
module bitins_mask_gen
   import bitins_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int POS_W      = 5,
   parameter int SIZE_W     = 5,
   parameter int SUM_W      = 6,
   parameter int MASK_STYLE = MASK_THERMO
) (
   input  logic [POS_W-1:0]  fld_pos,
   input  logic [SIZE_W-1:0] fld_len,
   input  logic [SUM_W-1:0]  fld_end,
   input  logic              fld_ok,
   output logic [DATA_W-1:0] mask
);

   if (MASK_STYLE != MASK_SHIFT && MASK_STYLE != MASK_THERMO) begin : g_bad_style
      $error("unknown mask style");
   end

   if (MASK_STYLE == MASK_SHIFT) begin : g_shift
      logic [DATA_W:0] ones_w;
      always_comb begin
         ones_w = ({{DATA_W{1'b0}}, 1'b1} << fld_len) - 1'b1;
         mask   = fld_ok ? (ones_w[DATA_W-1:0] << fld_pos) : '0;
      end
   end else begin : g_thermo
      // each bit compares its own index against the run bounds
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         localparam logic [SUM_W-1:0] IDX = SUM_W'(i);
         assign mask[i] = fld_ok && (IDX >= SUM_W'(fld_pos)) && (IDX < fld_end);
      end
   end

   // R2: the number of selected bits equals the run length, or zero when refused
   always_comb begin
      assert_mask_width_R2 : assert ($countones(mask) == (fld_ok ? int'(fld_len) : 0))
         else $error("mask popcount mismatch");
   end

endmodule

// File: rtl/bitins_bit_rev.sv
module bitins_bit_rev #(
   parameter int DATA_W = 32,
   parameter int REV_W  = 16
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   if (REV_W < 1 || REV_W > DATA_W) begin : g_bad_rev
      $error("reverse span must fit inside the data word");
   end

   for (genvar i = 0; i < REV_W; i++) begin : g_mirror
      assign dout[i] = din[REV_W-1-i];
   end

   if (REV_W < DATA_W) begin : g_upper
      assign dout[DATA_W-1:REV_W] = '0;
   end

endmodule

// File: rtl/bitfield_insert_unit.sv
module bitfield_insert_unit
   import bitins_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CTRL_W     = 32,
   parameter int POS_LSB    = 0,
   parameter int POS_W      = 5,
   parameter int SIZE_LSB   = 7,
   parameter int SIZE_W     = 5,
   parameter int REV_W      = 16,
   parameter int MASK_STYLE = MASK_THERMO
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_op,
   input  logic [31:0]       in_rs,
   input  logic [31:0]       in_rt,
   input  logic [31:0]       in_ctrl,
   output logic              out_valid,
   output logic [31:0]       out_data
);

   localparam int SUM_W = ((POS_W > SIZE_W) ? POS_W : SIZE_W) + 1;

   if (DATA_W != 32 || CTRL_W != 32) begin : g_bad_port
      $error("port widths are fixed at 32 bits");
   end

   logic [POS_W-1:0]  fld_pos;
   logic [SIZE_W-1:0] fld_len;
   logic [SUM_W-1:0]  fld_end;
   logic              fld_ok;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] ins_word;
   logic [DATA_W-1:0] rev_word;
   logic [DATA_W-1:0] nxt_word;
   bitins_op_e        op;

   bitins_field_decode #(
      .DATA_W  (DATA_W),
      .CTRL_W  (CTRL_W),
      .POS_LSB (POS_LSB),
      .POS_W   (POS_W),
      .SIZE_LSB(SIZE_LSB),
      .SIZE_W  (SIZE_W),
      .SUM_W   (SUM_W)
   ) u_decode (
      .ctrl   (in_ctrl),
      .fld_pos(fld_pos),
      .fld_len(fld_len),
      .fld_end(fld_end),
      .fld_ok (fld_ok)
   );

   bitins_mask_gen #(
      .DATA_W    (DATA_W),
      .POS_W     (POS_W),
      .SIZE_W    (SIZE_W),
      .SUM_W     (SUM_W),
      .MASK_STYLE(MASK_STYLE)
   ) u_mask (
      .fld_pos(fld_pos),
      .fld_len(fld_len),
      .fld_end(fld_end),
      .fld_ok (fld_ok),
      .mask   (mask)
   );

   bitins_bit_rev #(
      .DATA_W(DATA_W),
      .REV_W (REV_W)
   ) u_rev (
      .din (in_rt),
      .dout(rev_word)
   );

   always_comb begin
      op       = bitins_op_e'(in_op);
      // source bits stay at their own indices
      ins_word = (in_rs & mask) | (in_rt & ~mask);
      nxt_word = (op == OP_BITREV) ? rev_word : ins_word;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= nxt_word;
         end
      end
   end

   // R6: one-cycle latency of the valid strobe
   assert_valid_follows_R6 : assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_valid_drops_R6 : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   assert_hold_idle_R6 : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data));

   // R3: empty run passes the destination through
   assert_empty_run_R3 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_op && fld_len == '0) |=> (out_data == $past(in_rt)));

   // R4: run crossing the word top passes the destination through
   assert_past_top_R4 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_op && (fld_end > SUM_W'(DATA_W))) |=> (out_data == $past(in_rt)));

   // R5: reverse mode leaves the upper part zero
   assert_rev_upper_R5 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op) |=> (out_data[31:REV_W] == '0));

   // R7: reset clears the outputs
   assert_reset_clear_R7 : assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));

endmodule

// File: tb/bitfield_insert_unit_tb.sv
module bitfield_insert_unit_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_op = 1'b0;
   logic [31:0] in_rs = '0;
   logic [31:0] in_rt = '0;
   logic [31:0] in_ctrl = '0;
   logic        out_valid;
   logic [31:0] out_data;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   bitfield_insert_unit u_dut (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_op    (in_op),
      .in_rs    (in_rs),
      .in_rt    (in_rt),
      .in_ctrl  (in_ctrl),
      .out_valid(out_valid),
      .out_data (out_data)
   );

   function automatic logic [31:0] ref_insert(logic [31:0] rs, logic [31:0] rt,
                                              int pos, int len);
      logic [31:0] r;
      r = rt;
      if (len == 0 || pos + len > 32) return rt;
      for (int i = pos; i < pos + len; i++) r[i] = rs[i];
      return r;
   endfunction

   function automatic logic [31:0] ref_reverse(logic [31:0] rt);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < 16; i++) r[15-i] = rt[i];
      return r;
   endfunction

   function automatic logic [31:0] mk_ctrl(int pos, int len);
      return (32'(len & 31) << 7) | 32'(pos & 31);
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   // drive at negedge, result visible at the following negedge
   task automatic apply(logic op, logic [31:0] rs, logic [31:0] rt, logic [31:0] ctrl);
      in_valid = 1'b1;
      in_op    = op;
      in_rs    = rs;
      in_rt    = rt;
      in_ctrl  = ctrl;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 out_valid", {31'b0, out_valid}, 32'd0);
      check("R7 out_data", out_data, 32'd0);
      rst = 1'b0;
   endtask

   task automatic t_sweep(logic [31:0] rs, logic [31:0] rt);
      for (int p = 0; p < 32; p++) begin
         for (int s = 0; s < 32; s++) begin
            apply(1'b0, rs, rt, mk_ctrl(p, s));
            if (s == 0)
               check("R3", out_data, ref_insert(rs, rt, p, s));
            else if (p + s > 32)
               check("R4", out_data, ref_insert(rs, rt, p, s));
            else
               check("R2", out_data, ref_insert(rs, rt, p, s));
         end
      end
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_ctrl_noise();
      logic [31:0] rs = 32'h1357_9BDF;
      logic [31:0] rt = 32'hECA8_6420;
      int cases[6][2] = '{'{0,1}, '{3,7}, '{16,16}, '{0,32 & 31}, '{31,1}, '{20,13}};
      for (int k = 0; k < 6; k++) begin
         apply(1'b0, rs, rt, mk_ctrl(cases[k][0], cases[k][1]) | 32'hFFFF_F060);
         check("R1 noise", out_data, ref_insert(rs, rt, cases[k][0], cases[k][1]));
      end
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reverse();
      logic [31:0] pats[5] = '{32'h0000_0001, 32'hFFFF_8000, 32'h1234_C3A5,
                               32'hDEAD_0F0E, 32'h5555_AAAA};
      for (int k = 0; k < 5; k++) begin
         apply(1'b1, ~pats[k], pats[k], mk_ctrl(k * 3, 5 + k));
         check("R5", out_data, ref_reverse(pats[k]));
      end
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_latency();
      logic [31:0] exp;
      exp = ref_insert(32'hFFFF_FFFF, 32'h0, 8, 8);
      apply(1'b0, 32'hFFFF_FFFF, 32'h0, mk_ctrl(8, 8));
      check("R6 valid high", {31'b0, out_valid}, 32'd1);
      check("R6 data", out_data, exp);
      in_valid = 1'b0;
      in_rs    = 32'h0;
      in_rt    = 32'hFFFF_FFFF;
      in_ctrl  = mk_ctrl(0, 31);
      @(negedge clk);
      check("R6 valid low", {31'b0, out_valid}, 32'd0);
      check("R6 hold", out_data, exp);
      in_op = 1'b1;
      @(negedge clk);
      check("R6 hold2", out_data, exp);
      in_op = 1'b0;
      // reset after activity
      apply(1'b0, 32'hFFFF_FFFF, 32'h0, mk_ctrl(0, 4));
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      check("R7 mid valid", {31'b0, out_valid}, 32'd0);
      check("R7 mid data", out_data, 32'd0);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_latency();
      t_sweep(32'hA5C3_9E17, 32'h5A3C_61E8);
      t_sweep(32'hFFFF_FFFF, 32'h0000_0000);
      t_ctrl_noise();
      t_reverse();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule